// File: doc/BRIEF.md
# Zero-Overhead Loop Controller with Loop-Tail Branch Check

This block sits next to instruction fetch and runs a hardware loop without any loop-closing instruction. A setup event loads three values: the address of the first body instruction, the address just past the body, and the iteration count. While the count is nonzero the loop is active. The block then watches every retiring instruction. A retiring instruction is the body's last one when its address plus its length (2 or 4 bytes) equals the stored end address. When such an instruction retires, the block either sends fetch back to the body start or lets execution run on past the end.

Some branch placements at the tail are illegal. In the high-performance variant any branch as the last body instruction is an error. In the embedded variant only a delayed branch there is an error, because its delay slot would fall outside the body. The error is raised whatever the branch outcome would be. On an error the block captures a fixed cause code and the faulting address, returning the latter both as return address and as fault address. It reports a zero saved branch target and a zero saved status. It also redirects fetch to the handler at a vector base plus a fixed offset. All outputs are registered, so each outcome appears one clock after the retire that caused it.

Top module: `zol_ctrl`

## Requirements
- R1: After a synchronous active-high reset, redir_valid and exc_valid are 0, all captured exception values are 0, and the loop is inactive (count 0).
- R2: A setup event loads start, end and count. A retire presented in the same cycle as setup has no loop or fault effect.
- R3: A retire is the loop tail only when the loop is active and ret_pc + (ret_len4 ? 4 : 2) equals the stored end address. A retire that is not a tail produces no redirect and no fault.
- R4: A non-faulting tail retire with count greater than 1 decrements the count and gives redir_valid=1 with redir_pc equal to the loop start one cycle later.
- R5: A non-faulting tail retire with count equal to 1 sets the count to 0 and produces no redirect, so execution falls through. The count never rises except by setup.
- R6: With mode=1 (high-performance), any branch (ret_branch=1) at the tail faults, delayed or not.
- R7: With mode=0 (embedded), only a delayed branch (ret_branch=1 and ret_delayed=1) at the tail faults. A non-delayed branch at the tail is handled as in R4/R5.
- R8: A fault gives exc_valid=1 and redir_valid=1 with redir_pc = vec_base + IERR_OFF one cycle later. It takes priority over loop-back and leaves the count unchanged.
- R9: On a fault, exc_cause becomes 0x00020100, exc_ret and exc_fault both become the faulting ret_pc, and exc_bta and exc_status become 0. These values hold until the next fault.
- R10: While the count is 0, no retire causes a redirect or a fault.
- R11: redir_valid and exc_valid are single-cycle results. Both are 0 in any cycle that follows a cycle with no retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 1 = high-performance tail rule, 0 = embedded tail rule |
| setup_valid | input | 1 | Loop setup event |
| setup_start | input | AW | Address of first body instruction |
| setup_end | input | AW | Address just past the body |
| setup_count | input | CW | Iteration count |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_len4 | input | 1 | 1 = 4-byte instruction, 0 = 2-byte |
| ret_branch | input | 1 | Retiring instruction is a branch |
| ret_delayed | input | 1 | Branch has a delay slot |
| vec_base | input | AW | Exception vector base |
| redir_valid | output | 1 | Fetch redirect request |
| redir_pc | output | AW | Redirect target |
| exc_valid | output | 1 | Instruction-error exception raised |
| exc_cause | output | DW | Captured cause code |
| exc_ret | output | AW | Captured return address |
| exc_fault | output | AW | Captured fault address |
| exc_bta | output | AW | Captured branch target (always 0) |
| exc_status | output | DW | Captured saved status (always 0) |

## Verification
The bench builds the block with AW=16, CW=4 and IERR_OFF=0x10. The narrow count keeps multi-pass loops short, so loop-back, final pass and loop-inactive states are all reached within a few vectors. The 16-bit addresses let the 2-byte and 4-byte tail alignments be placed exactly at the end address, and also one slot short of it. With a vector base of 0x0100, the handler target 0x0110 is distinct from the loop start, so a fault that loses priority to loop-back shows up at redir_pc.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic {MODE_EMB = 1'b0, MODE_PERF = 1'b1} zol_mode_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_LOOP, ACT_EXIT, ACT_FAULT} zol_act_e;
  localparam logic [31:0] IERR_CAUSE = 32'h0002_0100;
endpackage

// File: rtl/zol_loop_regs.sv
module zol_loop_regs
  import zol_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          setup_valid,
  input  logic [AW-1:0] setup_start,
  input  logic [AW-1:0] setup_end,
  input  logic [CW-1:0] setup_count,
  input  zol_act_e      act,
  output logic [AW-1:0] lp_start,
  output logic [AW-1:0] lp_end,
  output logic [CW-1:0] lp_count,
  output logic          lp_active
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_start <= '0;
      lp_end   <= '0;
      lp_count <= '0;
    end else if (setup_valid) begin
      lp_start <= setup_start;
      lp_end   <= setup_end;
      lp_count <= setup_count;
    end else if (act == ACT_LOOP || act == ACT_EXIT) begin
      lp_count <= lp_count - ONE;
    end
  end

  assign lp_active = (lp_count != '0);

  // count only rises through setup
  assert_count_nonincr_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(setup_valid) |-> (lp_count <= $past(lp_count)));

  // a fault leaves the iteration count untouched
  assert_fault_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(act) == ACT_FAULT && !$past(setup_valid)) |-> $stable(lp_count));
endmodule

// File: rtl/zol_tail_check.sv
module zol_tail_check
  import zol_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  zol_mode_e     mode,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic          ret_len4,
  input  logic          ret_branch,
  input  logic          ret_delayed,
  input  logic          setup_valid,
  input  logic          lp_active,
  input  logic [AW-1:0] lp_end,
  input  logic [CW-1:0] lp_count,
  output zol_act_e      act
);
  localparam logic [AW-1:0] LEN_W = AW'(4);
  localparam logic [AW-1:0] LEN_H = AW'(2);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [AW-1:0] next_seq;
  logic          is_tail;
  logic          bad_tail;

  assign next_seq = ret_pc + (ret_len4 ? LEN_W : LEN_H);
  assign is_tail  = ret_valid && lp_active && !setup_valid && (next_seq == lp_end);

  always_comb begin
    if (mode == MODE_PERF) bad_tail = ret_branch;
    else                   bad_tail = ret_branch && ret_delayed;
  end

  always_comb begin
    if (!is_tail)               act = ACT_NONE;
    else if (bad_tail)          act = ACT_FAULT;
    else if (lp_count > ONE)    act = ACT_LOOP;
    else                        act = ACT_EXIT;
  end

  always_comb begin
    if (act == ACT_FAULT && mode == MODE_EMB)
      assert_emb_needs_delay_R7: assert (ret_delayed);
    if (act == ACT_FAULT)
      assert_fault_is_branch_R6: assert (ret_branch);
    if (act != ACT_NONE)
      assert_tail_only_active_R10: assert (lp_active);
  end
endmodule

// File: rtl/zol_exc_capture.sv
module zol_exc_capture
  import zol_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] IERR_OFF = AW'(32'h40)
) (
  input  logic          clk,
  input  logic          rst,
  input  zol_act_e      act,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] vec_base,
  input  logic [AW-1:0] lp_start,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          exc_valid,
  output logic [DW-1:0] exc_cause,
  output logic [AW-1:0] exc_ret,
  output logic [AW-1:0] exc_fault,
  output logic [AW-1:0] exc_bta,
  output logic [DW-1:0] exc_status
);
  localparam logic [DW-1:0] CAUSE = DW'(IERR_CAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      exc_valid   <= 1'b0;
      exc_cause   <= '0;
      exc_ret     <= '0;
      exc_fault   <= '0;
      exc_bta     <= '0;
      exc_status  <= '0;
    end else begin
      redir_valid <= 1'b0;
      exc_valid   <= 1'b0;
      case (act)
        ACT_FAULT: begin
          redir_valid <= 1'b1;
          redir_pc    <= vec_base + IERR_OFF;
          exc_valid   <= 1'b1;
          exc_cause   <= CAUSE;
          exc_ret     <= ret_pc;
          exc_fault   <= ret_pc;
          exc_bta     <= '0;
          exc_status  <= '0;
        end
        ACT_LOOP: begin
          redir_valid <= 1'b1;
          redir_pc    <= lp_start;
        end
        default: ;
      endcase
    end
  end

  assert_fault_redirects_R8: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (redir_valid && redir_pc == $past(vec_base) + IERR_OFF));
  assert_cause_code_R9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause == CAUSE && exc_bta == '0 && exc_status == '0));
  assert_fault_addr_R9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_ret == $past(ret_pc) && exc_fault == $past(ret_pc)));
  assert_capture_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |-> ($stable(exc_ret) && $stable(exc_cause)));
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            CW       = 16,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] IERR_OFF = AW'(32'h40)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          setup_valid,
  input  logic [AW-1:0] setup_start,
  input  logic [AW-1:0] setup_end,
  input  logic [CW-1:0] setup_count,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic          ret_len4,
  input  logic          ret_branch,
  input  logic          ret_delayed,
  input  logic [AW-1:0] vec_base,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          exc_valid,
  output logic [DW-1:0] exc_cause,
  output logic [AW-1:0] exc_ret,
  output logic [AW-1:0] exc_fault,
  output logic [AW-1:0] exc_bta,
  output logic [DW-1:0] exc_status
);
  zol_act_e      act;
  zol_mode_e     mode_e;
  logic [AW-1:0] lp_start;
  logic [AW-1:0] lp_end;
  logic [CW-1:0] lp_count;
  logic          lp_active;

  assign mode_e = zol_mode_e'(mode);

  zol_loop_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .setup_valid(setup_valid), .setup_start(setup_start),
    .setup_end(setup_end), .setup_count(setup_count),
    .act(act),
    .lp_start(lp_start), .lp_end(lp_end),
    .lp_count(lp_count), .lp_active(lp_active)
  );

  zol_tail_check #(.AW(AW), .CW(CW)) u_tail (
    .mode(mode_e), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_len4(ret_len4), .ret_branch(ret_branch), .ret_delayed(ret_delayed),
    .setup_valid(setup_valid), .lp_active(lp_active),
    .lp_end(lp_end), .lp_count(lp_count), .act(act)
  );

  zol_exc_capture #(.AW(AW), .DW(DW), .IERR_OFF(IERR_OFF)) u_exc (
    .clk(clk), .rst(rst), .act(act), .ret_pc(ret_pc),
    .vec_base(vec_base), .lp_start(lp_start),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_ret(exc_ret), .exc_fault(exc_fault),
    .exc_bta(exc_bta), .exc_status(exc_status)
  );

  assert_quiet_without_retire_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(ret_valid) |-> (!redir_valid && !exc_valid));
  assert_setup_blocks_retire_R2: assert property (@(posedge clk) disable iff (rst)
    $past(setup_valid) |-> (!redir_valid && !exc_valid));
endmodule

// File: tb/tb_zol_ctrl.sv
module tb_zol_ctrl;
  localparam int AW = 16;
  localparam int CW = 4;
  localparam int DW = 32;
  localparam logic [AW-1:0] OFF   = 16'h0010;
  localparam logic [AW-1:0] VBASE = 16'h0100;
  localparam logic [AW-1:0] HANDLER = 16'h0110;
  localparam logic [AW-1:0] LSTART = 16'h0116;
  localparam logic [AW-1:0] LEND   = 16'h011E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic setup_valid = 1'b0;
  logic [AW-1:0] setup_start = '0, setup_end = '0;
  logic [CW-1:0] setup_count = '0;
  logic ret_valid = 1'b0, ret_len4 = 1'b0, ret_branch = 1'b0, ret_delayed = 1'b0;
  logic [AW-1:0] ret_pc = '0;
  logic [AW-1:0] vec_base = VBASE;
  logic redir_valid, exc_valid;
  logic [AW-1:0] redir_pc, exc_ret, exc_fault, exc_bta;
  logic [DW-1:0] exc_cause, exc_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zol_ctrl #(.AW(AW), .CW(CW), .DW(DW), .IERR_OFF(OFF)) dut (
    .clk(clk), .rst(rst), .mode(mode),
    .setup_valid(setup_valid), .setup_start(setup_start),
    .setup_end(setup_end), .setup_count(setup_count),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_len4(ret_len4),
    .ret_branch(ret_branch), .ret_delayed(ret_delayed), .vec_base(vec_base),
    .redir_valid(redir_valid), .redir_pc(redir_pc),
    .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_ret(exc_ret), .exc_fault(exc_fault),
    .exc_bta(exc_bta), .exc_status(exc_status)
  );

  typedef struct packed {
    logic          su;
    logic [CW-1:0] cnt;
    logic          md;
    logic [AW-1:0] pc;
    logic          l4;
    logic          br;
    logic          dl;
    logic          e_rv;
    logic [AW-1:0] e_pc;
    logic          e_ex;
  } vec_t;

  // start 0x0116, end 0x011E; handler 0x0110
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd2, 1'b1, 16'h011A-16'h0004, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0}, // R3 not tail
    '{1'b0, 4'd0, 1'b1, 16'h011A, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0116, 1'b0},          // R4 loop back
    '{1'b0, 4'd0, 1'b1, 16'h011A, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},          // R5 fall through
    '{1'b0, 4'd0, 1'b1, 16'h011A, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0},          // R10 inactive
    '{1'b1, 4'd2, 1'b1, 16'h011A, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0110, 1'b1},          // R6 branch faults
    '{1'b0, 4'd0, 1'b0, 16'h011A, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0116, 1'b0},          // R7 plain branch ok, R8 count kept
    '{1'b1, 4'd2, 1'b0, 16'h011A, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0110, 1'b1},          // R7 delayed faults
    '{1'b1, 4'd3, 1'b0, 16'h011C, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0116, 1'b0},          // R3 2-byte tail
    '{1'b0, 4'd0, 1'b0, 16'h011C, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0},          // R3 overshoot
    '{1'b0, 4'd0, 1'b1, 16'h011C, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0110, 1'b1}           // R6 delayed in perf mode
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_setup(input logic [CW-1:0] cnt);
    @(negedge clk);
    setup_valid = 1'b1; setup_start = LSTART; setup_end = LEND; setup_count = cnt;
    @(negedge clk);
    setup_valid = 1'b0;
  endtask

  task automatic retire(input logic md, input logic [AW-1:0] pc,
                        input logic l4, input logic br, input logic dl);
    mode = md; ret_valid = 1'b1; ret_pc = pc; ret_len4 = l4;
    ret_branch = br; ret_delayed = dl;
    @(negedge clk);
    ret_valid = 1'b0; ret_branch = 1'b0; ret_delayed = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 redir_valid", 32'(redir_valid), 32'd0);
    chk("R1 exc_valid",   32'(exc_valid),   32'd0);
    chk("R1 exc_cause",   exc_cause,        32'd0);
    chk("R1 exc_ret",     32'(exc_ret),     32'd0);
    // R10 inactive after reset: tail branch does nothing
    retire(1'b1, 16'h011A, 1'b1, 1'b1, 1'b0);
    chk("R10 redir after reset", 32'(redir_valid), 32'd0);
    chk("R10 exc after reset",   32'(exc_valid),   32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].su) do_setup(VECS[i].cnt);
      retire(VECS[i].md, VECS[i].pc, VECS[i].l4, VECS[i].br, VECS[i].dl);
      chk($sformatf("R3/R4/R6/R7/R8 vec%0d redir_valid", i), 32'(redir_valid), 32'(VECS[i].e_rv));
      if (VECS[i].e_rv)
        chk($sformatf("R4/R8 vec%0d redir_pc", i), 32'(redir_pc), 32'(VECS[i].e_pc));
      chk($sformatf("R6/R7 vec%0d exc_valid", i), 32'(exc_valid), 32'(VECS[i].e_ex));
    end

    // R9 captured values of a fault
    do_setup(4'd2);
    retire(1'b1, 16'h011A, 1'b1, 1'b1, 1'b0);
    chk("R9 exc_cause",  exc_cause,          32'h0002_0100);
    chk("R9 exc_ret",    32'(exc_ret),       32'h011A);
    chk("R9 exc_fault",  32'(exc_fault),     32'h011A);
    chk("R9 exc_bta",    32'(exc_bta),       32'd0);
    chk("R9 exc_status", exc_status,         32'd0);
    chk("R8 handler pc", 32'(redir_pc),      32'(HANDLER));
    // R11 pulse ends without retire; R9 values held
    @(negedge clk);
    chk("R11 exc_valid drops",   32'(exc_valid),   32'd0);
    chk("R11 redir_valid drops", 32'(redir_valid), 32'd0);
    chk("R9 exc_ret held",       32'(exc_ret),     32'h011A);
    // R9 non-fault tail does not alter capture
    retire(1'b1, 16'h011A, 1'b1, 1'b0, 1'b0);
    chk("R4 loop after fault", 32'(redir_valid), 32'd1);
    chk("R9 exc_fault held",   32'(exc_fault),   32'h011A);

    // R2 setup with simultaneous tail retire: retire ignored, count exactly 2
    @(negedge clk);
    setup_valid = 1'b1; setup_start = LSTART; setup_end = LEND; setup_count = 4'd2;
    retire(1'b1, 16'h011A, 1'b1, 1'b1, 1'b0);
    setup_valid = 1'b0;
    chk("R2 no redirect during setup", 32'(redir_valid), 32'd0);
    chk("R2 no fault during setup",    32'(exc_valid),   32'd0);
    retire(1'b1, 16'h011A, 1'b1, 1'b0, 1'b0);
    chk("R2 first pass loops", 32'(redir_valid), 32'd1);
    retire(1'b1, 16'h011A, 1'b1, 1'b0, 1'b0);
    chk("R5 last pass exits",  32'(redir_valid), 32'd0);
    retire(1'b1, 16'h011A, 1'b1, 1'b1, 1'b1);
    chk("R10 done loop no fault", 32'(exc_valid), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule